// File: doc/BRIEF.md
# Four-Pin Multi-Mode GPIO Controller with Pulse Bursts

The block controls four general-purpose pins. Each pin has its own 32-bit control word, and a single write/read port with a pin select reaches every word. The mode field in that word makes a pin one of five things: a sampled input, a driven output, a source of asynchronous trigger events, a strobe slot, or a pulse generator. Each pin is modelled as an input level, an output level and an output enable. One trigger output collects the rising edges seen on all pins that are in trigger mode.

In pulse mode a pin emits a burst of a programmed number of pulses. The active and idle phase lengths come from parameters. The count field is read back live and falls by one as each pulse period ends. At zero the burst stops and the count is not reloaded. A count of 0xFF keeps the pulses going forever. A running burst accepts a new nonzero count only after a zero has been written to it. Another pin, after synchronization, can gate the burst. The level on that pin that pauses the burst is selectable. While the burst is paused, the phase and the count are frozen.

Top module: `gpio_pwm_ctrl`

## Requirements
- R1: After reset every pin is in input mode, `pin_oe_o` is all zero and `trig_o` is low. A read always returns 1 in bit 31 and 0 in bits 30:20, even after writes that set those bits.
- R2: Bits 19:16 hold the mode: 0 input, 1 output, 2 trigger, 3 strobe, 4 pulse. Output mode drives `pin_oe_o` high with `pin_o` equal to bit 0. Input, trigger, strobe and undefined modes keep `pin_oe_o` low.
- R3: In input mode, read bit 0 returns the pin level as seen through a two-flop synchronizer.
- R4: For a pin in trigger mode, each rising edge on `pin_i` raises `trig_o` for exactly one clock cycle.
- R5: A write of mode 4 with a nonzero count in bits 15:8, made while the count is zero, starts a burst. From the cycle after the write, each pulse is active for HIGH_CYCLES clocks and then inactive for LOW_CYCLES clocks. The count read in bits 15:8 falls by one at the end of each period.
- R6: When the count reaches zero, the pulses stop, the output stays at its inactive level and the count stays at zero.
- R7: A count of 0xFF produces pulses without end and reads back 0xFF.
- R8: A nonzero count written while the count is nonzero is ignored. A written zero clears the count. A rejected write that lands on a period end does not block that period's decrement.
- R9: In pulse mode, bit 0 sets the polarity. With 1 the pulses are high and the idle level is low. With 0 the pulses are low and the idle level is high.
- R10: In pulse mode, bit 1 turns gating on, bits 6:4 select the gating pin (the low two bits are used), and bit 2 is the level of that pin's synchronized input that pauses the burst. While paused, the output is inactive and the count is frozen. The burst resumes when the level changes.
- R11: Writing any mode other than 4 clears the pulse count, and the count reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the selected control word |
| sel_i | input | 2 | Pin select for write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected pin |
| pin_i | input | 4 | Pin input levels |
| pin_o | output | 4 | Pin output levels |
| pin_oe_o | output | 4 | Pin output enables |
| trig_o | output | 1 | One-cycle trigger pulse |

## Verification
A register write and the decrement at the end of a pulse period can land on the same clock edge. The bench loads a count of one and then issues a write of a different nonzero count timed for the exact edge that ends the last period. The count must then read zero, which shows that the write was refused and the decrement still happened. A following write of the same count must be accepted, because the field is now zero.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 8;

  typedef enum logic [3:0] {
    MODE_IN     = 4'd0,
    MODE_OUT    = 4'd1,
    MODE_TRIG   = 4'd2,
    MODE_STROBE = 4'd3,
    MODE_PWM    = 4'd4
  } gpio_mode_e;

  // control word field positions (LSB = 0)
  localparam int PRES_BIT  = 31;
  localparam int MODE_LSB  = 16;
  localparam int CNT_LSB   = 8;
  localparam int GSEL_LSB  = 4;
  localparam int DPOL_BIT  = 2;
  localparam int GEN_BIT   = 1;
  localparam int DATA_BIT  = 0;

  localparam logic [CNT_W-1:0] CNT_FOREVER = '1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign q_o    = stg_q[STAGES-1];
  assign rise_o = q_o & ~prev_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    a_r4_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[i] |=> !rise_o[i]);
  end
endmodule

// File: rtl/gpio_pwm.sv
module gpio_pwm
  import gpio_pkg::*;
#(
  parameter int HIGH_CYCLES = 3,
  parameter int LOW_CYCLES  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_mode_i,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             hold_i,
  output logic             active_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int PERIOD = HIGH_CYCLES + LOW_CYCLES;
  localparam int PW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] HI_LAST  = PW'(HIGH_CYCLES);
  localparam logic [PW-1:0] PER_LAST = PW'(PERIOD - 1);

  logic [PW-1:0]    cyc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run;

  assign run = pwm_mode_i && (cnt_q != '0) && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cyc_q <= '0;
      cnt_q <= '0;
    end else if (load_i && cnt_q == '0) begin
      cyc_q <= '0;
      cnt_q <= load_val_i;
    end else if (run) begin
      if (cyc_q == PER_LAST) begin
        cyc_q <= '0;
        if (cnt_q != CNT_FOREVER) cnt_q <= cnt_q - 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  assign active_o = run && (cyc_q < HI_LAST);
  assign count_o  = cnt_q;

  a_r7_forever_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_FOREVER && !clr_i) |=> cnt_q == CNT_FOREVER);
  a_r6_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> cnt_q == '0);
  a_r10_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !clr_i && !load_i) |=> $stable(cnt_q) && !$past(active_o));
  a_r8_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i && cnt_q != '0) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/gpio_pwm_ctrl.sv
module gpio_pwm_ctrl
  import gpio_pkg::*;
#(
  parameter int N_PINS      = 4,
  parameter int HIGH_CYCLES = 3,
  parameter int LOW_CYCLES  = 5,
  parameter int SYNC_STAGES = 2,
  localparam int SW         = (N_PINS > 1) ? $clog2(N_PINS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SW-1:0]     sel_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic              trig_o
);
  logic [N_PINS-1:0][3:0]       mode_q;
  logic [N_PINS-1:0]            data_q, dpol_q, gen_q;
  logic [N_PINS-1:0][2:0]       gsel_q;
  logic [N_PINS-1:0][CNT_W-1:0] cnt_w;
  logic [N_PINS-1:0]            act_w, hold_w, clr_w, load_w, trig_en;
  logic [N_PINS-1:0]            pin_s, pin_rise;

  logic [3:0]       w_mode;
  logic [CNT_W-1:0] w_cnt;
  assign w_mode = wdata_i[MODE_LSB +: 4];
  assign w_cnt  = wdata_i[CNT_LSB +: CNT_W];

  gpio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (pin_i),
    .q_o (pin_s), .rise_o (pin_rise)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      data_q <= '0;
      dpol_q <= '0;
      gen_q  <= '0;
      gsel_q <= '0;
    end else if (wr_en_i) begin
      for (int p = 0; p < N_PINS; p++) begin
        if (sel_i == SW'(p)) begin
          mode_q[p] <= w_mode;
          data_q[p] <= wdata_i[DATA_BIT];
          dpol_q[p] <= wdata_i[DPOL_BIT];
          gen_q[p]  <= wdata_i[GEN_BIT];
          gsel_q[p] <= wdata_i[GSEL_LSB +: 3];
        end
      end
    end
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic wr_me;
    logic [SW-1:0] gidx;
    assign wr_me     = wr_en_i && (sel_i == SW'(p));
    assign gidx      = gsel_q[p][SW-1:0];
    assign clr_w[p]  = wr_me && (w_mode != MODE_PWM || w_cnt == '0);
    assign load_w[p] = wr_me && (w_mode == MODE_PWM) && (w_cnt != '0);
    assign hold_w[p] = gen_q[p] && (pin_s[gidx] == dpol_q[p]);
    assign trig_en[p] = (mode_q[p] == MODE_TRIG);

    gpio_pwm #(.HIGH_CYCLES(HIGH_CYCLES), .LOW_CYCLES(LOW_CYCLES)) pwm_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pwm_mode_i (mode_q[p] == MODE_PWM),
      .clr_i      (clr_w[p]),
      .load_i     (load_w[p]),
      .load_val_i (w_cnt),
      .hold_i     (hold_w[p]),
      .active_o   (act_w[p]),
      .count_o    (cnt_w[p])
    );

    always_comb begin
      pin_oe_o[p] = 1'b0;
      pin_o[p]    = 1'b0;
      case (mode_q[p])
        MODE_OUT: begin
          pin_oe_o[p] = 1'b1;
          pin_o[p]    = data_q[p];
        end
        MODE_PWM: begin
          pin_oe_o[p] = 1'b1;
          pin_o[p]    = data_q[p] ? act_w[p] : ~act_w[p];
        end
        default: ;
      endcase
    end

    a_r11_idle_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q[p] != MODE_PWM) |-> cnt_w[p] == '0);
    a_r2_drive_modes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_oe_o[p] |-> (mode_q[p] == MODE_OUT || mode_q[p] == MODE_PWM));
  end

  assign trig_o = |(pin_rise & trig_en);

  always_comb begin
    rdata_o = '0;
    rdata_o[PRES_BIT] = 1'b1;
    rdata_o[MODE_LSB +: 4] = mode_q[sel_i];
    case (mode_q[sel_i])
      MODE_IN:            rdata_o[DATA_BIT] = pin_s[sel_i];
      MODE_OUT, MODE_TRIG: rdata_o[DATA_BIT] = data_q[sel_i];
      MODE_PWM: begin
        rdata_o[CNT_LSB +: CNT_W] = cnt_w[sel_i];
        rdata_o[GSEL_LSB +: 3]    = gsel_q[sel_i];
        rdata_o[DPOL_BIT]         = dpol_q[sel_i];
        rdata_o[GEN_BIT]          = gen_q[sel_i];
        rdata_o[DATA_BIT]         = data_q[sel_i];
      end
      default: ;
    endcase
  end

  a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[31:20] == 12'h800);
endmodule

// File: tb/gpio_pwm_ctrl_tb.sv
module gpio_pwm_ctrl_tb_top;
  localparam int HI = 3;
  localparam int LO = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pin_in = '0;
  logic [3:0]  pin_out, pin_oe;
  logic        trig;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_pwm_ctrl #(.HIGH_CYCLES(HI), .LOW_CYCLES(LO)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .sel_i (sel),
    .wdata_i (wdata), .rdata_o (rdata), .pin_i (pin_in),
    .pin_o (pin_out), .pin_oe_o (pin_oe), .trig_o (trig)
  );

  function automatic logic [31:0] mk(input logic [3:0] mode, input logic [7:0] cnt,
                                     input logic [2:0] gs, input logic dp,
                                     input logic ge, input logic b0);
    return {1'b0, 11'b0, mode, cnt, 1'b0, gs, 1'b0, dp, ge, b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] p, input logic [31:0] w);
    @(negedge clk);
    sel = p; wdata = w; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] p, output logic [31:0] v);
    sel = p;
    #1;
    v = rdata;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v);
    chk("R1 reset word", v, 32'h8000_0000);
    chk("R1 reset oe", {28'b0, pin_oe}, 32'h0);
    chk("R1 reset trig", {31'b0, trig}, 32'h0);
  endtask

  task automatic t_output();
    logic [31:0] v;
    wr(2'd1, mk(4'd1, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1) | 32'h7FF0_0000);
    chk("R2 output oe", {31'b0, pin_oe[1]}, 32'h1);
    chk("R2 output level", {31'b0, pin_out[1]}, 32'h1);
    rd(2'd1, v);
    chk("R1 reserved read", {20'b0, v[31:20]}, 32'h800);
    chk("R2 mode read", {28'b0, v[19:16]}, 32'h1);
  endtask

  task automatic t_input();
    logic [31:0] v;
    @(negedge clk); pin_in[2] = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd2, v);
    chk("R3 input sampled", {31'b0, v[0]}, 32'h1);
    chk("R2 input released", {31'b0, pin_oe[2]}, 32'h0);
  endtask

  task automatic t_trigger();
    int hits = 0;
    wr(2'd3, mk(4'd2, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0));
    chk("R2 trigger released", {31'b0, pin_oe[3]}, 32'h0);
    pin_in[3] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (trig) hits++;
    end
    chk("R4 single trigger", hits, 1);
  endtask

  task automatic t_burst();
    int act = 0;
    logic [31:0] v;
    wr(2'd0, mk(4'd4, 8'd3, 3'd0, 1'b0, 1'b0, 1'b1));
    rd(2'd0, v);
    chk("R5 count after load", {24'b0, v[15:8]}, 32'd3);
    for (int i = 0; i < 30; i++) begin
      if (pin_out[0]) act++;
      @(negedge clk);
    end
    chk("R5 active cycles", act, 3 * HI);
    rd(2'd0, v);
    chk("R6 count stays zero", {24'b0, v[15:8]}, 32'd0);
    chk("R6 idle level", {31'b0, pin_out[0]}, 32'h0);
  endtask

  task automatic t_polarity();
    int low = 0;
    wr(2'd0, mk(4'd4, 8'd2, 3'd0, 1'b0, 1'b0, 1'b0));
    for (int i = 0; i < 24; i++) begin
      if (!pin_out[0]) low++;
      @(negedge clk);
    end
    chk("R9 active-low pulses", low, 2 * HI);
    chk("R9 idle high", {31'b0, pin_out[0]}, 32'h1);
  endtask

  task automatic t_reject();
    logic [31:0] v;
    wr(2'd0, mk(4'd4, 8'd5, 3'd0, 1'b0, 1'b0, 1'b1));
    wr(2'd0, mk(4'd4, 8'd7, 3'd0, 1'b0, 1'b0, 1'b1));
    rd(2'd0, v);
    chk("R8 rejected rewrite", {24'b0, v[15:8]}, 32'd5);
    wr(2'd0, mk(4'd4, 8'd0, 3'd0, 1'b0, 1'b0, 1'b1));
    rd(2'd0, v);
    chk("R8 zero clears", {24'b0, v[15:8]}, 32'd0);
    wr(2'd0, mk(4'd4, 8'd7, 3'd0, 1'b0, 1'b0, 1'b1));
    rd(2'd0, v);
    chk("R8 accepted after zero", {24'b0, v[15:8]}, 32'd7);
    wr(2'd0, mk(4'd4, 8'd0, 3'd0, 1'b0, 1'b0, 1'b1));
  endtask

  task automatic t_forever();
    int rises = 0;
    logic prev = 1'b0;
    logic [31:0] v;
    wr(2'd0, mk(4'd4, 8'hFF, 3'd0, 1'b0, 1'b0, 1'b1));
    for (int i = 0; i < 48; i++) begin
      if (pin_out[0] && !prev) rises++;
      prev = pin_out[0];
      @(negedge clk);
    end
    rd(2'd0, v);
    chk("R7 count holds 0xFF", {24'b0, v[15:8]}, 32'hFF);
    chk("R7 pulses continue", rises, 6);
    wr(2'd0, mk(4'd4, 8'd0, 3'd0, 1'b0, 1'b0, 1'b1));
  endtask

  task automatic t_gate();
    logic [31:0] v;
    logic [7:0] c1;
    wr(2'd0, mk(4'd4, 8'd4, 3'd2, 1'b0, 1'b1, 1'b1));
    repeat (5) @(negedge clk);
    pin_in[2] = 1'b0;
    repeat (4) @(negedge clk);
    rd(2'd0, v);
    c1 = v[15:8];
    repeat (20) @(negedge clk);
    rd(2'd0, v);
    chk("R10 count frozen", {24'b0, v[15:8]}, {24'b0, c1});
    chk("R10 output inactive", {31'b0, pin_out[0]}, 32'h0);
    pin_in[2] = 1'b1;
    repeat (60) @(negedge clk);
    rd(2'd0, v);
    chk("R10 burst resumed to end", {24'b0, v[15:8]}, 32'd0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(2'd0, mk(4'd4, 8'd1, 3'd0, 1'b0, 1'b0, 1'b1));
    repeat (HI + LO - 1) @(posedge clk);
    wr(2'd0, mk(4'd4, 8'd9, 3'd0, 1'b0, 1'b0, 1'b1));
    rd(2'd0, v);
    chk("R8 write at period end rejected", {24'b0, v[15:8]}, 32'd0);
    wr(2'd0, mk(4'd4, 8'd9, 3'd0, 1'b0, 1'b0, 1'b1));
    rd(2'd0, v);
    chk("R8 load after natural end", {24'b0, v[15:8]}, 32'd9);
  endtask

  task automatic t_leave();
    logic [31:0] v;
    wr(2'd0, mk(4'd1, 8'd0, 3'd0, 1'b0, 1'b0, 1'b0));
    chk("R2 output low", {30'b0, pin_oe[0], pin_out[0]}, 32'h2);
    wr(2'd0, mk(4'd4, 8'd0, 3'd0, 1'b0, 1'b0, 1'b1));
    rd(2'd0, v);
    chk("R11 count cleared on mode change", {24'b0, v[15:8]}, 32'd0);
    wr(2'd0, mk(4'd3, 8'd0, 3'd0, 1'b0, 1'b0, 1'b1));
    chk("R2 strobe released", {31'b0, pin_oe[0]}, 32'h0);
    wr(2'd0, mk(4'd9, 8'd0, 3'd0, 1'b0, 1'b0, 1'b1));
    chk("R2 undefined released", {31'b0, pin_oe[0]}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_output();
    t_input();
    t_trigger();
    t_burst();
    t_polarity();
    t_reject();
    t_forever();
    t_gate();
    t_collide();
    t_leave();
    done = 1;
    summary();
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end
endmodule